// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits between a logic client and the request/response port of an existing management-bus (MDIO) master. The client asks for one logical register access: a 5-bit target device address, a 5-bit register address, a direction, and 16-bit write data. The sequencer turns that request into the raw clause-22 bus accesses that a multi-chip switch needs, and returns read data together with a one-cycle `done` or `err` pulse.

When the configured chip bus address is zero, the chip answers on every bus address. In that case the request becomes a single direct bus access. For any other chip address the sequencer runs a two-register indirection. It polls a command register until its busy bit clears, loads a data register when the access is a write, and writes a command word. It then polls again and, for a read, fetches the data register. Each poll is bounded by a retry limit with a fixed wait between attempts. Running out of attempts, or an error from any raw access, ends the request at once with `err`.

Top module: `smi_indirect_seq`

## Requirements
- R1: With `cfg_bus_addr` equal to 0, a request produces exactly one raw access. That access uses `req_dev` as the bus address and `req_reg` as the register, with the same direction and write data. A successful read returns the raw read data on `rdata` with `done`.
- R2: With a nonzero `cfg_bus_addr`, every raw access uses `cfg_bus_addr` as its bus address. The command register is at register 0 and the data register is at register 1.
- R3: The command word has bit 15 set (busy), bit 12 set (clause-22 marker), bits 11:10 = 2 for a read or 1 for a write, bits 9:5 = `req_dev` and bits 4:0 = `req_reg`. All other bits are 0.
- R4: An indirect read issues these raw accesses in order: polls of register 0 until idle, a write of the command word to register 0, polls of register 0 until idle, and a read of register 1. The result of that last read is returned on `rdata` with `done`.
- R5: An indirect write issues these raw accesses in order: polls of register 0 until idle, a write of `req_wdata` to register 1, a write of the command word to register 0, and polls of register 0 until idle. It then pulses `done`.
- R6: A poll is a raw read of register 0. It counts as idle exactly when bit 15 of the returned data is 0, whatever the other bits hold.
- R7: If `POLL_LIMIT` consecutive polls in one polling phase all read busy, `err` pulses and no further raw access is issued. The attempt count restarts for each polling phase and each request.
- R8: A raw response with `mio_fail` set ends the request in that cycle: `err` pulses, `done` stays low, and no further raw access is issued. This holds in both direct and indirect mode.
- R9: `req_ready` is high when the block is idle. It is low from the cycle after acceptance until the cycle that carries the single `done` or `err` pulse, so a request held on the inputs during an access is not taken again. `done` and `err` are never high together.
- R10: A new raw access is presented two clock cycles after the cycle carrying a response. When that response was a busy poll with attempts remaining, it is presented `DELAY_CYC` cycles later than that.
- R11: `mio_valid` is low after reset. While a raw access awaits its response, `mio_valid` and all its fields hold steady. `mio_valid` drops in the cycle after `mio_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_addr | input | 5 | Configured chip bus address; 0 selects direct mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address inside the chip |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle pulse: request completed |
| err | output | 1 | One-cycle pulse: timeout or raw failure |
| rdata | output | 16 | Read result, updated with `done` of a read |
| mio_valid | output | 1 | Raw access presented to the bus master |
| mio_write | output | 1 | Raw access direction |
| mio_phy | output | 5 | Raw bus address |
| mio_reg | output | 5 | Raw register address |
| mio_wdata | output | 16 | Raw write data |
| mio_ack | input | 1 | One-cycle response pulse from the bus master |
| mio_fail | input | 1 | Response carries an error |
| mio_rdata | input | 16 | Response read data |

## Verification
The bench builds the block with `POLL_LIMIT` = 4 and `DELAY_CYC` = 5. This makes a full poll timeout take only a few dozen cycles. It also allows the exact wait between polls to be measured against a response latency of three cycles. With these values, several busy polls can be run in each phase, a timeout can be triggered, and a recovery request with one busy poll fewer than the limit can follow it. That last case shows that the attempt count restarts.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;

  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned BUSY_POS = 15;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 5'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_POLL,
    ST_DELAY,
    ST_LOAD,
    ST_ISSUE,
    ST_FETCH
  } seq_state_e;

  // busy | 00 | clause-22 | opcode | device | register
  function automatic logic [DATA_W-1:0] build_cmd(input logic wr,
                                                  input logic [ADDR_W-1:0] dev,
                                                  input logic [ADDR_W-1:0] rg);
    logic [1:0] op;
    op = wr ? 2'b01 : 2'b10;
    return {1'b1, 2'b00, 1'b1, op, dev, rg};
  endfunction

endpackage

// File: rtl/smi_poll_ctrl.sv
module smi_poll_ctrl #(
  parameter int unsigned POLL_LIMIT = 100,
  parameter int unsigned DELAY_CYC  = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic busy_i,
  output logic last_o,
  output logic expire_o
);

  localparam int unsigned AW = $clog2(POLL_LIMIT + 1);
  localparam int unsigned DW = $clog2(DELAY_CYC + 1);

  logic [AW-1:0] attempts;
  logic [DW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      attempts <= '0;
      wait_cnt <= '0;
    end else begin
      if (busy_i) begin
        attempts <= attempts + 1'b1;
        wait_cnt <= DW'(DELAY_CYC);
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  assign last_o   = (attempts == AW'(POLL_LIMIT - 1));
  assign expire_o = (wait_cnt == DW'(1));

endmodule

// File: rtl/smi_raw_port.sv
module smi_raw_port
  import smi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              retire_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic [DATA_W-1:0] wdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      write_o <= 1'b0;
      phy_o   <= '0;
      reg_o   <= '0;
      wdata_o <= '0;
    end else if (launch_i) begin
      valid_o <= 1'b1;
      write_o <= write_i;
      phy_o   <= phy_i;
      reg_o   <= reg_i;
      wdata_o <= wdata_i;
    end else if (retire_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/smi_indirect_seq.sv
module smi_indirect_seq
  import smi_seq_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 100,
  parameter int unsigned DELAY_CYC  = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_bus_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_dev,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              mio_valid,
  output logic              mio_write,
  output logic [ADDR_W-1:0] mio_phy,
  output logic [ADDR_W-1:0] mio_reg,
  output logic [DATA_W-1:0] mio_wdata,
  input  logic              mio_ack,
  input  logic              mio_fail,
  input  logic [DATA_W-1:0] mio_rdata
);

  seq_state_e        state;
  logic              post_phase;
  logic              r_write;
  logic [ADDR_W-1:0] r_chip, r_dev, r_reg;
  logic [DATA_W-1:0] r_wdata;

  logic              accept, rsp_ok, rsp_bad, bus_state, launch, retire;
  logic              poll_clr, poll_busy, poll_last, poll_expire, busy_seen;
  logic              l_write;
  logic [ADDR_W-1:0] l_phy, l_reg;
  logic [DATA_W-1:0] l_wdata;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign retire    = mio_valid && mio_ack;
  assign rsp_ok    = retire && !mio_fail;
  assign rsp_bad   = retire && mio_fail;
  assign busy_seen = mio_rdata[BUSY_POS];
  assign bus_state = state inside {ST_DIRECT, ST_POLL, ST_LOAD, ST_ISSUE, ST_FETCH};
  assign launch    = bus_state && !mio_valid;
  assign poll_clr  = accept || ((state == ST_ISSUE) && rsp_ok);
  assign poll_busy = (state == ST_POLL) && rsp_ok && busy_seen && !poll_last;

  // raw access contents for each bus step
  always_comb begin
    l_write = 1'b0;
    l_phy   = r_chip;
    l_reg   = OFS_CMD;
    l_wdata = '0;
    case (state)
      ST_DIRECT: begin
        l_write = r_write;
        l_phy   = r_dev;
        l_reg   = r_reg;
        l_wdata = r_wdata;
      end
      ST_LOAD: begin
        l_write = 1'b1;
        l_reg   = OFS_DATA;
        l_wdata = r_wdata;
      end
      ST_ISSUE: begin
        l_write = 1'b1;
        l_wdata = build_cmd(r_write, r_dev, r_reg);
      end
      ST_FETCH: l_reg = OFS_DATA;
      default: ;
    endcase
  end

  smi_poll_ctrl #(
    .POLL_LIMIT(POLL_LIMIT),
    .DELAY_CYC (DELAY_CYC)
  ) u_poll (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (poll_clr),
    .busy_i  (poll_busy),
    .last_o  (poll_last),
    .expire_o(poll_expire)
  );

  smi_raw_port u_port (
    .clk     (clk),
    .rst     (rst),
    .launch_i(launch),
    .retire_i(retire),
    .write_i (l_write),
    .phy_i   (l_phy),
    .reg_i   (l_reg),
    .wdata_i (l_wdata),
    .valid_o (mio_valid),
    .write_o (mio_write),
    .phy_o   (mio_phy),
    .reg_o   (mio_reg),
    .wdata_o (mio_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      post_phase <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
      r_write    <= 1'b0;
      r_chip     <= '0;
      r_dev      <= '0;
      r_reg      <= '0;
      r_wdata    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (state == ST_IDLE) begin
        if (req_valid) begin
          r_write    <= req_write;
          r_chip     <= cfg_bus_addr;
          r_dev      <= req_dev;
          r_reg      <= req_reg;
          r_wdata    <= req_wdata;
          post_phase <= 1'b0;
          state      <= (cfg_bus_addr == '0) ? ST_DIRECT : ST_POLL;
        end
      end else if (state == ST_DELAY) begin
        if (poll_expire) state <= ST_POLL;
      end else if (rsp_bad) begin
        err   <= 1'b1;
        state <= ST_IDLE;
      end else if (rsp_ok) begin
        if (state == ST_DIRECT) begin
          done <= 1'b1;
          if (!r_write) rdata <= mio_rdata;
          state <= ST_IDLE;
        end else if (state == ST_POLL) begin
          if (busy_seen) begin
            if (poll_last) begin
              err   <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_DELAY;
            end
          end else if (!post_phase) begin
            state <= r_write ? ST_LOAD : ST_ISSUE;
          end else if (r_write) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_FETCH;
          end
        end else if (state == ST_LOAD) begin
          state <= ST_ISSUE;
        end else if (state == ST_ISSUE) begin
          post_phase <= 1'b1;
          state      <= ST_POLL;
        end else begin
          rdata <= mio_rdata;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/smi_seq_checker.sv
module smi_seq_checker (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  cfg_bus_addr,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        err,
  input logic        mio_valid,
  input logic        mio_write,
  input logic [4:0]  mio_phy,
  input logic [4:0]  mio_reg,
  input logic [15:0] mio_wdata,
  input logic        mio_ack
);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (mio_valid && !mio_ack) |=> (mio_valid && $stable(mio_write) && $stable(mio_phy)
                                 && $stable(mio_reg) && $stable(mio_wdata)));

  p_drop_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (mio_valid && mio_ack) |=> !mio_valid);

  p_chip_addr_used_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(mio_valid) && cfg_bus_addr != 5'd0) |-> (mio_phy == cfg_bus_addr));

  p_cmd_word_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (mio_valid && cfg_bus_addr != 5'd0 && mio_write && mio_reg == 5'd0)
      |-> (mio_wdata[15] && mio_wdata[12]
           && (mio_wdata[11:10] == 2'b01 || mio_wdata[11:10] == 2'b10)));

  p_quiet_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !mio_valid);

endmodule

bind smi_indirect_seq smi_seq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_bus_addr(cfg_bus_addr),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .err         (err),
  .mio_valid   (mio_valid),
  .mio_write   (mio_write),
  .mio_phy     (mio_phy),
  .mio_reg     (mio_reg),
  .mio_wdata   (mio_wdata),
  .mio_ack     (mio_ack)
);

// File: tb/smi_indirect_seq_tb.sv
module smi_indirect_seq_tb;

  localparam int DLY = 5;
  localparam int LIM = 4;
  localparam int LAT = 3;
  localparam int G0  = 2;
  localparam int GD  = 2 + DLY;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  cfg_bus_addr;
  logic        req_valid, req_ready, req_write;
  logic [4:0]  req_dev, req_reg;
  logic [15:0] req_wdata;
  logic        done, err;
  logic [15:0] rdata;
  logic        mio_valid, mio_write;
  logic [4:0]  mio_phy, mio_reg;
  logic [15:0] mio_wdata;
  logic        mio_ack, mio_fail;
  logic [15:0] mio_rdata;

  always #5 clk = ~clk;

  smi_indirect_seq #(.POLL_LIMIT(LIM), .DELAY_CYC(DLY)) u_dut (
    .clk(clk), .rst(rst), .cfg_bus_addr(cfg_bus_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata),
    .mio_valid(mio_valid), .mio_write(mio_write), .mio_phy(mio_phy),
    .mio_reg(mio_reg), .mio_wdata(mio_wdata),
    .mio_ack(mio_ack), .mio_fail(mio_fail), .mio_rdata(mio_rdata)
  );

  typedef struct packed {
    logic        w;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        rerr;
    logic [15:0] rd;
  } exp_t;

  exp_t q[$];
  int   gq[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  int   ncnt = 0;
  int   last_rsp = -100;
  int   lat = 0;
  bit   rbusy = 0;
  bit   inflight = 0;
  int   cyc = 0;

  function automatic logic [15:0] cmdw(bit wr, logic [4:0] d, logic [4:0] r);
    return 16'h8000 + 16'h1000 + (wr ? 16'h0400 : 16'h0800) + (16'(d) << 5) + 16'(r);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic expect_raw(bit w, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                            int gap, bit rerr, logic [15:0] rd);
    exp_t e;
    e.w = w; e.phy = phy; e.rg = rg; e.wd = wd; e.rerr = rerr; e.rd = rd;
    q.push_back(e);
    gq.push_back(gap);
  endtask

  // behavioural bus master: scripted responses, command comparison
  always @(negedge clk) begin
    ncnt++;
    if (mio_ack) begin
      mio_ack  = 1'b0;
      mio_fail = 1'b0;
      rbusy    = 0;
    end else if (rbusy) begin
      chk(mio_valid && mio_phy == cur.phy && mio_reg == cur.rg && mio_write == cur.w,
          "R11", "raw access not held", 32'(mio_valid), 1);
      if (lat == 0) begin
        mio_ack   = 1'b1;
        mio_fail  = cur.rerr;
        mio_rdata = cur.rd;
        last_rsp  = ncnt;
      end else begin
        lat--;
      end
    end else if (mio_valid && !rst) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected raw access reg", 32'(mio_reg), 0);
        cur = '0;
      end else begin
        int g;
        cur = q.pop_front();
        g   = gq.pop_front();
        chk(mio_write == cur.w, "R2", "raw direction", 32'(mio_write), 32'(cur.w));
        chk(mio_phy == cur.phy, "R2", "raw bus address", 32'(mio_phy), 32'(cur.phy));
        chk(mio_reg == cur.rg, "R4", "raw register", 32'(mio_reg), 32'(cur.rg));
        if (cur.w)
          chk(mio_wdata == cur.wd, "R3", "raw write data", 32'(mio_wdata), 32'(cur.wd));
        if (g >= 0)
          chk(ncnt - last_rsp == g, "R10", "gap after response", ncnt - last_rsp, g);
        cur.phy = mio_phy; cur.rg = mio_reg; cur.w = mio_write;
      end
      rbusy = 1;
      lat   = LAT - 1;
    end
  end

  // per-clock handshake model
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (inflight) begin
        chk(req_ready == (done || err), "R9", "ready while busy", 32'(req_ready), 32'(done || err));
        if (done || err) inflight = 0;
      end else begin
        chk(!done && !err, "R9", "outcome without request", 32'(done || err), 0);
      end
      chk(!(done && err), "R9", "done and err together", 32'(done && err), 0);
      if (req_valid && req_ready) inflight = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(bit w, logic [4:0] d, logic [4:0] r, logic [15:0] wd,
                     bit exp_err, logic [15:0] exp_rd, bit chk_rd, string tag);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_dev = d; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_write = ~w; req_dev = ~d; req_reg = ~r; req_wdata = ~wd;
    n = 0;
    while (!(done || err) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(done == !exp_err, tag, "done", 32'(done), 32'(!exp_err));
    chk(err == exp_err, tag, "err", 32'(err), 32'(exp_err));
    if (chk_rd) chk(rdata == exp_rd, tag, "rdata", 32'(rdata), 32'(exp_rd));
    repeat (10) @(negedge clk);
    chk(q.size() == 0, tag, "expected raw accesses left", q.size(), 0);
  endtask

  initial begin
    rst = 1'b1; cfg_bus_addr = '0; req_valid = 1'b0; req_write = 1'b0;
    req_dev = '0; req_reg = '0; req_wdata = '0;
    mio_ack = 1'b0; mio_fail = 1'b0; mio_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
    chk(mio_valid == 1'b0, "R11", "raw valid after reset", 32'(mio_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R9", "outcome after reset", 32'(done || err), 0);

    // R1 direct read and write
    cfg_bus_addr = 5'd0;
    expect_raw(0, 5'h11, 5'h02, 16'h0, -1, 0, 16'hBEEF);
    run(0, 5'h11, 5'h02, 16'h0, 0, 16'hBEEF, 1, "R1");
    expect_raw(1, 5'h04, 5'h1F, 16'hA5A5, -1, 0, 16'h0);
    run(1, 5'h04, 5'h1F, 16'hA5A5, 0, 16'h0, 0, "R1");

    // R4 indirect read, R6 idle poll with other bits set
    cfg_bus_addr = 5'h03;
    expect_raw(0, 5'h03, 5'd0, 16'h0, -1, 0, 16'h0000);
    expect_raw(1, 5'h03, 5'd0, cmdw(0, 5'h1C, 5'h18), G0, 0, 16'h0);
    expect_raw(0, 5'h03, 5'd0, 16'h0, G0, 0, 16'h7FFF);
    expect_raw(0, 5'h03, 5'd1, 16'h0, G0, 0, 16'h5A3C);
    run(0, 5'h1C, 5'h18, 16'h0, 0, 16'h5A3C, 1, "R4");

    // R5 indirect write with busy polls in both phases (R10 timing)
    expect_raw(0, 5'h03, 5'd0, 16'h0, -1, 0, 16'h8000);
    expect_raw(0, 5'h03, 5'd0, 16'h0, GD, 0, 16'hFFFF);
    expect_raw(0, 5'h03, 5'd0, 16'h0, GD, 0, 16'h0000);
    expect_raw(1, 5'h03, 5'd1, 16'h0001, G0, 0, 16'h0);
    expect_raw(1, 5'h03, 5'd0, cmdw(1, 5'h05, 5'h16), G0, 0, 16'h0);
    expect_raw(0, 5'h03, 5'd0, 16'h0, G0, 0, 16'h8000);
    expect_raw(0, 5'h03, 5'd0, 16'h0, GD, 0, 16'h0000);
    run(1, 5'h05, 5'h16, 16'h0001, 0, 16'h0, 0, "R5");

    // R7 timeout after LIM busy polls
    for (int i = 0; i < LIM; i++)
      expect_raw(0, 5'h03, 5'd0, 16'h0, (i == 0) ? -1 : GD, 0, 16'h8000);
    run(0, 5'h02, 5'h03, 16'h0, 1, 16'h0, 0, "R7");

    // R7 attempt count restarts: LIM-1 busy polls then success
    for (int i = 0; i < LIM - 1; i++)
      expect_raw(0, 5'h03, 5'd0, 16'h0, (i == 0) ? -1 : GD, 0, 16'h8000);
    expect_raw(0, 5'h03, 5'd0, 16'h0, GD, 0, 16'h0000);
    expect_raw(1, 5'h03, 5'd0, cmdw(0, 5'h0A, 5'h01), G0, 0, 16'h0);
    expect_raw(0, 5'h03, 5'd0, 16'h0, G0, 0, 16'h0000);
    expect_raw(0, 5'h03, 5'd1, 16'h0, G0, 0, 16'hC0DE);
    run(0, 5'h0A, 5'h01, 16'h0, 0, 16'hC0DE, 1, "R7");

    // R8 raw failure on the command write aborts
    expect_raw(0, 5'h03, 5'd0, 16'h0, -1, 0, 16'h0000);
    expect_raw(1, 5'h03, 5'd0, cmdw(0, 5'h07, 5'h09), G0, 1, 16'h0);
    run(0, 5'h07, 5'h09, 16'h0, 1, 16'h0, 0, "R8");

    // R8 raw failure in direct mode
    cfg_bus_addr = 5'd0;
    expect_raw(0, 5'h0A, 5'h01, 16'h0, -1, 1, 16'h1111);
    run(0, 5'h0A, 5'h01, 16'h0, 1, 16'h0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule